// File: doc/BRIEF.md
# Content-Addressable Memory Array

This block stores a small set of words and answers three kinds of request. A write puts the shared data input into the word picked by a write address. An address read returns one stored word, as any register file would. A search takes the same shared data input as a key and compares it against every stored word in the same cycle. The result is a registered vector with one bit per word, a miss flag, and the index of the lowest matching word.

Each word carries a valid bit. Reset clears every valid bit, and only a write sets one. A word whose valid bit is clear never reports a match, so an empty slot cannot alias a key of zero. A search can also run in read-back mode. The match lines then stand in for the address decoder, and the data output returns the lowest-index matching word instead of an addressed one. A search only compares and never changes what is stored.

Top module: `cam_array`

## Requirements
- R1: A write with `wr_en` high stores `din` in word `wr_addr` and marks that word valid. An address read with `rd_en` high puts word `rd_addr` on `dout` at the next clock edge.
- R2: After reset every word is invalid and holds zero. `match_vec` is all zero, `miss` is 1, `hit_idx` is 0 and `dout` is 0.
- R3: A word whose valid bit is clear never sets its bit in `match_vec`, even when its stored bits equal the key.
- R4: At the edge after `srch_en`, bit i of `match_vec` is 1 exactly when word i is valid and all its bits equal `din`. Without `srch_en`, `match_vec` holds its value.
- R5: `miss` is 1 exactly when `match_vec` has no bit set.
- R6: `hit_idx` is the lowest set position in `match_vec`, and 0 when `miss` is 1.
- R7: With `srch_en` and `match_rd` both high, `dout` at the next edge is the lowest-index matching word, or 0 on a miss. This request takes precedence over an address read in the same cycle.
- R8: A search or an address read in the same cycle as a write sees the contents from before that write.
- R9: A search leaves stored words unchanged, as an address read made afterwards shows.
- R10: Overwriting a word removes its old value from later searches. A single differing bit is enough to prevent a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | WIDTH | Write data and search key (shared) |
| wr_en | input | 1 | Write request |
| wr_addr | input | $clog2(WORDS) | Word written |
| rd_en | input | 1 | Address read request |
| rd_addr | input | $clog2(WORDS) | Word read |
| srch_en | input | 1 | Search request |
| match_rd | input | 1 | With srch_en: return the matched word on dout |
| dout | output | WIDTH | Registered read data |
| match_vec | output | WORDS | Registered per-word match lines |
| miss | output | 1 | No word matched in the last search |
| hit_idx | output | $clog2(WORDS) | Lowest matching word index |

## Verification
The hardest case to reach is a write and a search in the same cycle where the word being written would match the key. The key and the write data share one bus, so the written value always equals the key. The stimulus issues exactly that combination and expects a miss, then repeats the search alone and expects the hit. Invalid slots that still hold zero are searched with a zero key. Several words are loaded with one value, so the lowest-index rule and the precedence of read-back over address reads both show at the ports.

// File: rtl/cam_pkg.sv
// Shared types for the content-addressable memory.
// Assumes nothing beyond IEEE 1800-2017.
package cam_pkg;
    // Source of the registered data output for one cycle.
    typedef enum logic [1:0] {
        DSRC_HOLD  = 2'd0,
        DSRC_ADDR  = 2'd1,
        DSRC_MATCH = 2'd2
    } dout_src_e;
endpackage

// File: rtl/cam_entry.sv
// One stored word with its valid bit, its exact comparator and its
// registered match line. Assumes a write and a search in the same cycle
// compare against the value held before the write.
module cam_entry #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [WIDTH-1:0] din,
    input  logic             srch_en,
    output logic [WIDTH-1:0] data_q,
    output logic             valid_q,
    output logic             match_now,
    output logic             match_q
);
    // Exact compare, gated by the valid bit.
    always_comb begin
        match_now = valid_q && (data_q == din);
    end

    // Storage and valid bit update on a selected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else if (wr_sel) begin
            data_q  <= din;
            valid_q <= 1'b1;
        end
    end

    // Match line captured on a search, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else if (srch_en) begin
            match_q <= match_now;
        end
    end

    p_invalid_never_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_en && !valid_q) |=> !match_q);

    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (valid_q && data_q == $past(din)));

    p_match_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> $stable(match_q));
endmodule

// File: rtl/cam_prio_enc.sv
// Lowest-index priority encoder over a request vector.
// Assumes WIDTH_IDX is wide enough to hold N-1.
module cam_prio_enc #(
    parameter int N         = 8,
    parameter int WIDTH_IDX = 3
) (
    input  logic [N-1:0]         req,
    output logic [WIDTH_IDX-1:0] idx,
    output logic                 found
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = WIDTH_IDX'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cam_array.sv
// Content-addressable memory: addressed write and read, a parallel exact
// search with registered match lines, a miss flag, the lowest hit index,
// and an optional read-back of the matched word. Assumes WORDS >= 2.
module cam_array
    import cam_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WIDTH-1:0]         din,
    input  logic                     wr_en,
    input  logic [$clog2(WORDS)-1:0] wr_addr,
    input  logic                     rd_en,
    input  logic [$clog2(WORDS)-1:0] rd_addr,
    input  logic                     srch_en,
    input  logic                     match_rd,
    output logic [WIDTH-1:0]         dout,
    output logic [WORDS-1:0]         match_vec,
    output logic                     miss,
    output logic [$clog2(WORDS)-1:0] hit_idx
);
    localparam int AW = $clog2(WORDS);

    logic [WIDTH-1:0] word_arr [WORDS];
    logic [WORDS-1:0] valid_vec;
    logic [WORDS-1:0] hit_now;
    logic [AW-1:0]    hit_now_idx;
    logic             hit_now_any;
    logic [WIDTH-1:0] dout_q;
    logic             miss_q;
    logic [AW-1:0]    idx_q;
    dout_src_e        src;

    // One slice per stored word.
    for (genvar g = 0; g < WORDS; g++) begin : g_entry
        cam_entry #(.WIDTH(WIDTH)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_sel    (wr_en && (wr_addr == AW'(g))),
            .din       (din),
            .srch_en   (srch_en),
            .data_q    (word_arr[g]),
            .valid_q   (valid_vec[g]),
            .match_now (hit_now[g]),
            .match_q   (match_vec[g])
        );
    end

    cam_prio_enc #(.N(WORDS), .WIDTH_IDX(AW)) u_prio (
        .req   (hit_now),
        .idx   (hit_now_idx),
        .found (hit_now_any)
    );

    // Choose what drives the data output register this cycle.
    always_comb begin
        if (srch_en && match_rd) src = DSRC_MATCH;
        else if (rd_en)          src = DSRC_ADDR;
        else                     src = DSRC_HOLD;
    end

    // Data output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else begin
            case (src)
                DSRC_MATCH: dout_q <= hit_now_any ? word_arr[hit_now_idx] : '0;
                DSRC_ADDR:  dout_q <= word_arr[rd_addr];
                default:    dout_q <= dout_q;
            endcase
        end
    end

    // Miss flag and hit index, captured with the match lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_q <= 1'b1;
            idx_q  <= '0;
        end else if (srch_en) begin
            miss_q <= !hit_now_any;
            idx_q  <= hit_now_idx;
        end
    end

    assign dout    = dout_q;
    assign miss    = miss_q;
    assign hit_idx = idx_q;

    // Mask of positions below the reported index, for the priority check.
    logic [WORDS-1:0] below_mask;
    always_comb begin
        for (int i = 0; i < WORDS; i++) below_mask[i] = (AW'(i) < idx_q);
    end

    p_miss_is_nor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q == (match_vec == '0));

    p_idx_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_q |-> (match_vec[idx_q] && ((match_vec & below_mask) == '0)));

    p_idx_zero_on_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q |-> (idx_q == '0));

    p_readback_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_en && match_rd) |=> (dout_q == (miss_q ? '0 : $past(din))));
endmodule

// File: tb/tb_cam_array.sv
`timescale 1ns/1ps
module tb_cam_array;
    localparam int D  = 8;
    localparam int W  = 16;
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [W-1:0]  din;
    logic          wr_en, rd_en, srch_en, match_rd;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [W-1:0]  dout;
    logic [D-1:0]  match_vec;
    logic          miss;
    logic [AW-1:0] hit_idx;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cam_array #(.WORDS(D), .WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .wr_addr(wr_addr),
        .rd_en(rd_en), .rd_addr(rd_addr), .srch_en(srch_en), .match_rd(match_rd),
        .dout(dout), .match_vec(match_vec), .miss(miss), .hit_idx(hit_idx)
    );

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic          srch;
        logic          mrd;
        logic [2:0]    addr;
        logic [15:0]   data;
        logic          chk_m;
        logic [7:0]    exp_m;
        logic          chk_d;
        logic [15:0]   exp_d;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 17;
    // wr rd srch mrd addr data | chk_m exp_m | chk_d exp_d | req
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,3'd0,16'h1111,1'b1,8'h00,1'b1,16'h0000,4'd1},  // R1
        '{1'b1,1'b0,1'b0,1'b0,3'd1,16'h2222,1'b1,8'h00,1'b0,16'h0000,4'd1},  // R1
        '{1'b1,1'b0,1'b0,1'b0,3'd5,16'h1111,1'b1,8'h00,1'b0,16'h0000,4'd1},  // R1
        '{1'b0,1'b0,1'b1,1'b0,3'd0,16'h1111,1'b1,8'h21,1'b1,16'h0000,4'd4},  // R4 two hits
        '{1'b0,1'b0,1'b1,1'b1,3'd0,16'h2222,1'b1,8'h02,1'b1,16'h2222,4'd7},  // R7
        '{1'b0,1'b0,1'b1,1'b1,3'd0,16'h3333,1'b1,8'h00,1'b1,16'h0000,4'd7},  // R7 miss
        '{1'b0,1'b1,1'b0,1'b0,3'd5,16'h0000,1'b1,8'h00,1'b1,16'h1111,4'd1},  // R1 read
        '{1'b1,1'b0,1'b1,1'b0,3'd2,16'h4444,1'b1,8'h00,1'b1,16'h1111,4'd8},  // R8 pre-write
        '{1'b0,1'b0,1'b1,1'b0,3'd0,16'h4444,1'b1,8'h04,1'b0,16'h0000,4'd8},  // R8 after
        '{1'b1,1'b0,1'b0,1'b0,3'd0,16'h5555,1'b1,8'h04,1'b0,16'h0000,4'd4},  // R4 hold
        '{1'b0,1'b0,1'b1,1'b0,3'd0,16'h1111,1'b1,8'h20,1'b0,16'h0000,4'd10}, // R10
        '{1'b0,1'b1,1'b1,1'b1,3'd0,16'h2222,1'b1,8'h02,1'b1,16'h2222,4'd7},  // R7 precedence
        '{1'b0,1'b1,1'b0,1'b0,3'd1,16'h0000,1'b0,8'h00,1'b1,16'h2222,4'd9},  // R9
        '{1'b0,1'b1,1'b0,1'b0,3'd3,16'h0000,1'b0,8'h00,1'b1,16'h0000,4'd2},  // R2 cleared word
        '{1'b0,1'b0,1'b1,1'b0,3'd0,16'h0000,1'b1,8'h00,1'b0,16'h0000,4'd3},  // R3
        '{1'b1,1'b1,1'b0,1'b0,3'd1,16'h9999,1'b0,8'h00,1'b1,16'h2222,4'd8},  // R8 read
        '{1'b0,1'b1,1'b0,1'b0,3'd1,16'h0000,1'b0,8'h00,1'b1,16'h9999,4'd1}   // R1
    };

    task automatic fail_line(input int req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        n_fail++;
        $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    // Compares match lines plus the miss flag and index derived from them (R5, R6).
    task automatic check_match(input int req, input logic [D-1:0] em);
        logic [AW-1:0] ei = '0;
        for (int i = D - 1; i >= 0; i--) if (em[i]) ei = AW'(i);
        n_chk++;
        if (match_vec !== em) fail_line(req, "match_vec", 32'(match_vec), 32'(em));
        n_chk++;
        if (miss !== (em == '0)) fail_line(5, "miss", 32'(miss), 32'(em == '0));
        n_chk++;
        if (hit_idx !== ei) fail_line(6, "hit_idx", 32'(hit_idx), 32'(ei));
    endtask

    task automatic check_dout(input int req, input logic [W-1:0] ed);
        n_chk++;
        if (dout !== ed) fail_line(req, "dout", 32'(dout), 32'(ed));
    endtask

    task automatic drive(input logic w, input logic r, input logic s, input logic m,
                         input logic [AW-1:0] a, input logic [W-1:0] d);
        wr_en = w; rd_en = r; srch_en = s; match_rd = m;
        wr_addr = a; rd_addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0; srch_en = 0; match_rd = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; din = '0; wr_en = 0; rd_en = 0; srch_en = 0; match_rd = 0;
        wr_addr = '0; rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R2: reset state
        check_match(2, '0);
        check_dout(2, '0);

        for (int k = 0; k < NV; k++) begin
            drive(TBL[k].wr, TBL[k].rd, TBL[k].srch, TBL[k].mrd, TBL[k].addr, TBL[k].data);
            if (TBL[k].chk_m) check_match(int'(TBL[k].req), TBL[k].exp_m);
            if (TBL[k].chk_d) check_dout(int'(TBL[k].req), TBL[k].exp_d);
        end

        // R6/R7: every word holds the same value, lowest index wins
        for (int a = 0; a < D; a++) drive(1, 0, 0, 0, AW'(a), 16'h7777);
        drive(0, 0, 1, 1, '0, 16'h7777);
        check_match(6, 8'hFF);
        check_dout(7, 16'h7777);
        // R10: one differing bit gives no match
        drive(0, 0, 1, 0, '0, 16'h7776);
        check_match(10, 8'h00);
        // R4: top word only
        drive(1, 0, 0, 0, AW'(D - 1), 16'hABCD);
        drive(0, 0, 1, 1, '0, 16'hABCD);
        check_match(4, 8'h80);
        check_dout(7, 16'hABCD);

        // R2/R3: reset in mid-run clears everything; zero key finds nothing
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check_match(2, '0);
        check_dout(2, '0);
        drive(0, 0, 1, 1, '0, 16'h7777);
        check_match(3, 8'h00);
        drive(0, 0, 1, 0, '0, 16'h0000);
        check_match(3, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule